// File: doc/BRIEF.md
# Fraction-Format Floating-Point Multiplier

This block multiplies two words in a fast, lightly checked floating-point format. A word holds a sign bit at the top, then a biased characteristic of `CHAR_W` bits, then a fraction of `FRAC_W` bits. The fraction carries no implied leading one and is meant to sit in the range 0.1xxx in binary, so a word's value is the fraction times two to the power of the characteristic minus `2^(CHAR_W-1)`. The default configuration is a 64-bit word with 15 characteristic bits and 48 fraction bits.

The datapath has two register stages and accepts a new operand pair every cycle. The first stage forms the sign, the summed characteristic and the full double-width fraction product. The second stage classifies the summed characteristic, post-normalizes by at most one bit, truncates the fraction and registers the result. The range test uses the characteristic as it stands before normalization. A characteristic that falls into the bottom quarter of its field flushes the word to zero without any trap. A characteristic that reaches the top quarter raises the overflow flag and keeps its leading `11` pattern, so a caller can carry on computing with the marked value. The only operand check is a zero test on the fraction field.

The generate parameter `MUL_ARRAY` selects how the fraction product is built. When it is 0, the product comes from the multiply operator. When it is 1, the product is an explicit sum of shifted partial products.

Top module: `fracfmt_mul`

## Requirements
- R1: The result word is laid out as {sign, characteristic[CHAR_W-1:0], fraction[FRAC_W-1:0]}. When bit 2·FRAC_W-1 of the fraction product is 1, the result fraction is the top FRAC_W bits of that product, truncated with no rounding, and the result characteristic is the raw characteristic r = ca + cb − 2^(CHAR_W-1).
- R2: When bit 2·FRAC_W-1 of the fraction product is 0, the product is shifted left by one before truncation, and the result characteristic is r − 1.
- R3: The result sign bit is the XOR of the two operand sign bits whenever the result is not zero.
- R4: When r ≥ 3·2^(CHAR_W-2), the overflow flag is 1 and the result characteristic is r, clipped to all ones if r exceeds the field. That characteristic is not decremented by normalization, so its top two bits read 11. The fraction follows R1 and R2.
- R5: When r < 2^(CHAR_W-2), the whole result word is zero and the overflow flag is 0.
- R6: The range test uses r before normalization. With r = 2^(CHAR_W-2) and a product that needs the shift, the result is not zeroed, and its characteristic is 2^(CHAR_W-2) − 1.
- R7: An operand whose fraction field is all zeros forces a zero word and a clear overflow flag, whatever the other operand holds. This includes an overflowed operand.
- R8: `done_o` is high exactly two cycles after each cycle in which `start_i` is high, and at no other time. Back-to-back starts are accepted every cycle.
- R9: While reset is high, and in the cycle after it, `done_o`, `ovf_o` and `product_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Operand pair valid this cycle |
| op_a_i | input | 1+CHAR_W+FRAC_W | First operand word |
| op_b_i | input | 1+CHAR_W+FRAC_W | Second operand word |
| product_o | output | 1+CHAR_W+FRAC_W | Result word, valid with done_o |
| ovf_o | output | 1 | Overflow mark, valid with done_o |
| done_o | output | 1 | Result strobe, two cycles after start_i |

## Verification
The bench builds two copies of the block with CHAR_W = 4 and FRAC_W = 4: one with MUL_ARRAY = 0 and one with MUL_ARRAY = 1. Each operand then takes one of 288 values, covering both signs, all 16 characteristics, every normalized fraction and the zero fraction. Every ordered pair is driven back to back and checked against an arithmetic model, so each corner case is reached: both underflow and overflow boundaries, the single-bit normalization shift at the lowest legal characteristic, clipping of doubly overflowed characteristics, and zero against overflowed operands. A second phase with sparse starts exercises the strobe timing.

// File: rtl/fracfmt_pkg.sv
package fracfmt_pkg;
   // Classification of a summed characteristic before normalization.
   typedef enum logic [1:0] {
      RC_NORMAL = 2'd0,
      RC_OVER   = 2'd1,
      RC_UNDER  = 2'd2
   } range_e;
endpackage

// File: rtl/fracfmt_char_add.sv
// Sums two biased characteristics and removes one bias (raw r, signed).
module fracfmt_char_add #(
   parameter int CHAR_W = 15
) (
   input  logic [CHAR_W-1:0]        ca_i,
   input  logic [CHAR_W-1:0]        cb_i,
   output logic signed [CHAR_W+1:0] raw_o
);
   localparam int RW = CHAR_W + 2;
   localparam logic [RW-1:0] BIAS_V = RW'(1) << (CHAR_W - 1);

   logic [RW-1:0] sum;
   assign sum   = {2'b00, ca_i} + {2'b00, cb_i} - BIAS_V;
   assign raw_o = signed'(sum);
endmodule

// File: rtl/fracfmt_frac_mul.sv
// Full-width fraction product; MUL_ARRAY picks operator or partial-product sum.
module fracfmt_frac_mul #(
   parameter int FRAC_W    = 48,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic [FRAC_W-1:0]   fa_i,
   input  logic [FRAC_W-1:0]   fb_i,
   output logic [2*FRAC_W-1:0] prod_o
);
   localparam int PW = 2 * FRAC_W;

   logic [PW-1:0] fa_ext;
   logic [PW-1:0] fb_ext;
   assign fa_ext = {{FRAC_W{1'b0}}, fa_i};
   assign fb_ext = {{FRAC_W{1'b0}}, fb_i};

   generate
      if (MUL_ARRAY == 1'b0) begin : g_op
         assign prod_o = fa_ext * fb_ext;
      end else begin : g_array
         logic [PW-1:0] pp [FRAC_W];
         for (genvar i = 0; i < FRAC_W; i++) begin : g_pp
            assign pp[i] = fb_i[i] ? (fa_ext << i) : '0;
         end
         always_comb begin
            prod_o = '0;
            for (int k = 0; k < FRAC_W; k++) begin
               prod_o = prod_o + pp[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fracfmt_range.sv
// Range classification on the pre-normalization characteristic, and the
// characteristic finally written to the result word.
module fracfmt_range
   import fracfmt_pkg::*;
#(
   parameter int CHAR_W = 15
) (
   input  logic signed [CHAR_W+1:0] raw_i,
   input  logic                     shift_i,
   output range_e                   cls_o,
   output logic [CHAR_W-1:0]        char_o
);
   localparam int RW = CHAR_W + 2;
   localparam logic signed [RW-1:0] OVF_MIN = RW'(3 << (CHAR_W - 2));
   localparam logic signed [RW-1:0] UNF_LIM = RW'(1 << (CHAR_W - 2));
   localparam logic signed [RW-1:0] CMAX    = RW'((1 << CHAR_W) - 1);

   always_comb begin
      if (raw_i < UNF_LIM) begin
         cls_o  = RC_UNDER;
         char_o = '0;
      end else if (raw_i >= OVF_MIN) begin
         cls_o  = RC_OVER;
         char_o = (raw_i > CMAX) ? CMAX[CHAR_W-1:0] : raw_i[CHAR_W-1:0];
      end else begin
         cls_o  = RC_NORMAL;
         char_o = raw_i[CHAR_W-1:0] - {{(CHAR_W-1){1'b0}}, shift_i};
      end
   end
endmodule

// File: rtl/fracfmt_mul.sv
module fracfmt_mul
   import fracfmt_pkg::*;
#(
   parameter int CHAR_W    = 15,
   parameter int FRAC_W    = 48,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         start_i,
   input  logic [CHAR_W+FRAC_W:0]       op_a_i,
   input  logic [CHAR_W+FRAC_W:0]       op_b_i,
   output logic [CHAR_W+FRAC_W:0]       product_o,
   output logic                         ovf_o,
   output logic                         done_o
);
   localparam int W  = 1 + CHAR_W + FRAC_W;
   localparam int PW = 2 * FRAC_W;
   localparam int RW = CHAR_W + 2;

   generate
      if (CHAR_W < 3) begin : g_bad_char
         $error("fracfmt_mul: CHAR_W must be at least 3");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fracfmt_mul: FRAC_W must be at least 2");
      end
   endgenerate

   // Field split
   logic                 sa, sb;
   logic [CHAR_W-1:0]    ca, cb;
   logic [FRAC_W-1:0]    fa, fb;
   assign sa = op_a_i[W-1];
   assign sb = op_b_i[W-1];
   assign ca = op_a_i[W-2 -: CHAR_W];
   assign cb = op_b_i[W-2 -: CHAR_W];
   assign fa = op_a_i[FRAC_W-1:0];
   assign fb = op_b_i[FRAC_W-1:0];

   // Stage 1: characteristic sum and fraction product
   logic signed [RW-1:0] raw_c;
   logic [PW-1:0]        prod_c;

   fracfmt_char_add #(.CHAR_W(CHAR_W)) u_char (
      .ca_i (ca),
      .cb_i (cb),
      .raw_o(raw_c)
   );

   fracfmt_frac_mul #(.FRAC_W(FRAC_W), .MUL_ARRAY(MUL_ARRAY)) u_frac (
      .fa_i  (fa),
      .fb_i  (fb),
      .prod_o(prod_c)
   );

   logic                 s1_valid;
   logic                 s1_sign;
   logic                 s1_zero;
   logic signed [RW-1:0] s1_raw;
   logic [PW-1:0]        s1_prod;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         s1_valid <= 1'b0;
         s1_sign  <= 1'b0;
         s1_zero  <= 1'b0;
         s1_raw   <= '0;
         s1_prod  <= '0;
      end else begin
         s1_valid <= start_i;
         if (start_i) begin
            s1_sign <= sa ^ sb;
            s1_zero <= (fa == '0) || (fb == '0);
            s1_raw  <= raw_c;
            s1_prod <= prod_c;
         end
      end
   end

   // Stage 2: range test (pre-normalization), one-bit normalize, truncate
   logic              norm_shift;
   logic [FRAC_W-1:0] frac_n;
   range_e            cls;
   logic [CHAR_W-1:0] char_n;

   assign norm_shift = ~s1_prod[PW-1];
   assign frac_n     = norm_shift ? s1_prod[PW-2 -: FRAC_W] : s1_prod[PW-1 -: FRAC_W];

   fracfmt_range #(.CHAR_W(CHAR_W)) u_range (
      .raw_i  (s1_raw),
      .shift_i(norm_shift),
      .cls_o  (cls),
      .char_o (char_n)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         done_o    <= 1'b0;
         ovf_o     <= 1'b0;
         product_o <= '0;
      end else begin
         done_o <= s1_valid;
         if (s1_valid) begin
            if (s1_zero || (cls == RC_UNDER)) begin
               product_o <= '0;
               ovf_o     <= 1'b0;
            end else begin
               product_o <= {s1_sign, char_n, frac_n};
               ovf_o     <= (cls == RC_OVER);
            end
         end
      end
   end
endmodule

// File: rtl/fracfmt_mul_chk.sv
module fracfmt_mul_chk #(
   parameter int CHAR_W = 15,
   parameter int FRAC_W = 48
) (
   input logic                   clk_i,
   input logic                   rst_i,
   input logic                   start_i,
   input logic [CHAR_W+FRAC_W:0] op_a_i,
   input logic [CHAR_W+FRAC_W:0] op_b_i,
   input logic [CHAR_W+FRAC_W:0] product_o,
   input logic                   ovf_o,
   input logic                   done_o,
   input logic                   s1_valid,
   input logic                   s1_zero
);
   localparam int W = 1 + CHAR_W + FRAC_W;

   assert_latency_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> ##1 done_o);

   assert_no_stray_done_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !start_i |=> ##1 !done_o);

   assert_ovf_pattern_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && ovf_o) |-> (product_o[W-2 -: 2] == 2'b11));

   assert_zero_operand_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (s1_valid && s1_zero) |=> (product_o == '0 && !ovf_o));

   assert_sign_xor_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && product_o != '0) |->
         (product_o[W-1] == ($past(op_a_i[W-1], 2) ^ $past(op_b_i[W-1], 2))));

   assert_reset_clear_R9: assert property (@(posedge clk_i)
      $past(rst_i) |-> (!done_o && !ovf_o && product_o == '0));
endmodule

bind fracfmt_mul fracfmt_mul_chk #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .start_i  (start_i),
   .op_a_i   (op_a_i),
   .op_b_i   (op_b_i),
   .product_o(product_o),
   .ovf_o    (ovf_o),
   .done_o   (done_o),
   .s1_valid (s1_valid),
   .s1_zero  (s1_zero)
);

// File: tb/fracfmt_mul_test.sv
`timescale 1ns/1ps
module fracfmt_mul_test;
   localparam int CW   = 4;
   localparam int FW   = 4;
   localparam int W    = 1 + CW + FW;
   localparam int BIAS = 1 << (CW - 1);
   localparam int UNF  = 1 << (CW - 2);
   localparam int OVF  = 3 << (CW - 2);
   localparam int CMAX = (1 << CW) - 1;
   localparam int NOPS = 2 * (1 << CW) * 9;

   logic         clk_i = 1'b0;
   logic         rst_i = 1'b1;
   logic         start_i = 1'b0;
   logic [W-1:0] op_a_i = '0;
   logic [W-1:0] op_b_i = '0;
   logic [W-1:0] product_o, product_b;
   logic         ovf_o, ovf_b;
   logic         done_o, done_b;

   int  checks = 0;
   int  failures = 0;
   bit  finished = 1'b0;

   // expected pipeline: index 1 is what the outputs show now
   bit           p_valid [2];
   logic [W-1:0] p_word  [2];
   bit           p_ovf   [2];
   string        p_tag   [2];

   always #2 clk_i = ~clk_i;

   fracfmt_mul #(.CHAR_W(CW), .FRAC_W(FW), .MUL_ARRAY(1'b0)) uut (
      .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i),
      .product_o(product_o), .ovf_o(ovf_o), .done_o(done_o));

   fracfmt_mul #(.CHAR_W(CW), .FRAC_W(FW), .MUL_ARRAY(1'b1)) uut_b (
      .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i),
      .product_o(product_b), .ovf_o(ovf_b), .done_o(done_b));

   function automatic logic [W-1:0] op_of(input int idx);
      int s, c, fi, f;
      s  = idx / (NOPS / 2);
      c  = (idx % (NOPS / 2)) / 9;
      fi = idx % 9;
      f  = (fi == 0) ? 0 : 7 + fi;
      return {s[0], c[CW-1:0], f[FW-1:0]};
   endfunction

   // Arithmetic model of R1..R7
   task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] word, output bit ov, output string tag);
      int ca, cb, fa, fb, r, p, sh, fr, ch;
      bit s;
      ca = int'(a[W-2 -: CW]); cb = int'(b[W-2 -: CW]);
      fa = int'(a[FW-1:0]);    fb = int'(b[FW-1:0]);
      s  = a[W-1] ^ b[W-1];
      r  = ca + cb - BIAS;
      p  = fa * fb;
      sh = ((p >> (2*FW-1)) & 1) == 0 ? 1 : 0;
      fr = sh ? ((p >> (FW-1)) & ((1 << FW) - 1)) : ((p >> FW) & ((1 << FW) - 1));
      ov = 1'b0;
      if (fa == 0 || fb == 0) begin
         word = '0; tag = "R7";
      end else if (r < UNF) begin
         word = '0; tag = "R5";
      end else if (r >= OVF) begin
         ch = (r > CMAX) ? CMAX : r;
         ov = 1'b1;
         word = {s, ch[CW-1:0], fr[FW-1:0]}; tag = "R4";
      end else begin
         ch = r - sh;
         word = {s, ch[CW-1:0], fr[FW-1:0]};
         if (r == UNF && sh == 1) tag = "R6";
         else if (sh == 1) tag = "R2";
         else tag = "R1";
      end
   endtask

   task automatic check_now();
      checks++;
      if (done_o !== p_valid[1] || done_b !== p_valid[1]) begin
         failures++;
         $display("FAIL R8 done: actual %0b/%0b expected %0b", done_o, done_b, p_valid[1]);
      end
      if (p_valid[1]) begin
         checks++;
         if (product_o !== p_word[1] || ovf_o !== p_ovf[1]) begin
            failures++;
            $display("FAIL %s operator: actual %h ovf %0b expected %h ovf %0b",
                     p_tag[1], product_o, ovf_o, p_word[1], p_ovf[1]);
         end
         checks++;
         if (product_b !== p_word[1] || ovf_b !== p_ovf[1]) begin
            failures++;
            $display("FAIL %s array: actual %h ovf %0b expected %h ovf %0b",
                     p_tag[1], product_b, ovf_b, p_word[1], p_ovf[1]);
         end
         if (p_word[1] != '0) begin
            checks++; // R3 sign
            if (product_o[W-1] !== p_word[1][W-1]) begin
               failures++;
               $display("FAIL R3 sign: actual %0b expected %0b", product_o[W-1], p_word[1][W-1]);
            end
         end
      end
   endtask

   // drive at a falling edge, advance one cycle, check
   task automatic step(input bit st, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] w;
      bit           ov;
      string        tg;
      start_i = st; op_a_i = a; op_b_i = b;
      model(a, b, w, ov, tg);
      p_valid[1] = p_valid[0]; p_word[1] = p_word[0]; p_ovf[1] = p_ovf[0]; p_tag[1] = p_tag[0];
      p_valid[0] = st; p_word[0] = w; p_ovf[0] = ov; p_tag[0] = tg;
      @(negedge clk_i);
      check_now();
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         p_valid[i] = 1'b0; p_word[i] = '0; p_ovf[i] = 1'b0; p_tag[i] = "R1";
      end
      repeat (3) @(negedge clk_i);
      // R9: cleared while in reset, with operands present
      op_a_i = 9'h1FF; op_b_i = 9'h1FF;
      @(negedge clk_i);
      checks++;
      if (done_o !== 1'b0 || ovf_o !== 1'b0 || product_o !== '0) begin
         failures++;
         $display("FAIL R9 reset: actual done %0b ovf %0b prod %h expected 0 0 000",
                  done_o, ovf_o, product_o);
      end
      rst_i = 1'b0;
      @(negedge clk_i);
      checks++;
      if (done_o !== 1'b0 || ovf_o !== 1'b0 || product_o !== '0) begin
         failures++;
         $display("FAIL R9 after reset: actual done %0b ovf %0b prod %h expected 0 0 000",
                  done_o, ovf_o, product_o);
      end
      // Exhaustive sweep over all ordered pairs, back to back (R1..R8)
      for (int ia = 0; ia < NOPS; ia++) begin
         for (int ib = 0; ib < NOPS; ib++) begin
            step(1'b1, op_of(ia), op_of(ib));
         end
      end
      // Sparse starts: strobe timing with idle gaps (R8)
      for (int k = 0; k < 300; k++) begin
         step((k % 3) == 0 || (k % 7) == 1, op_of((k * 37) % NOPS), op_of((k * 53 + 11) % NOPS));
      end
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk_i);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual run still busy expected finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule